// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block takes charge of an asynchronous DRAM from reset until it is ready for traffic, and then keeps its contents alive. After reset it holds every strobe inactive for a programmable settling pause. It then runs a fixed number of initialization refresh cycles on its own. The bus carries no other traffic before the memory is declared ready, so these cycles need no grant. Each refresh is a CAS-before-RAS cycle, so the memory's internal row counter supplies the row and the block generates no address.

Once the memory is ready, an interval counter owes one refresh per refresh interval. The block raises a request towards the access controller. When it sees the grant, it drives the column strobe low, then the row strobe, and holds the write enable high for the whole cycle so the memory never treats the cycle as test-mode entry. It then restores both strobes and waits out the precharge time. The interval counter keeps running while a request waits. Missed intervals build up in a backlog of bounded depth and are served back to back. All timing is given in nanoseconds and converted to clock cycles, rounded up, with a minimum of one cycle.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted, the row, column and write strobes are high (inactive) and the ready, busy and request outputs are low.
- R2: After reset is released, all strobes stay high for P = ceil(T_PAUSE_NS*1000/CLK_PS) cycles, whatever the grant input does, and no request is raised. The first column-strobe fall is seen P+1 clock edges after release.
- R3: Exactly INIT_REFRESHES refresh cycles occur before the ready output rises. Ready is seen P + INIT_REFRESHES*(1+CSR+RAS+RP) + 1 edges after release, and it stays high from then on.
- R4: In every refresh cycle the column strobe is low for exactly CSR clock cycles while the row strobe is still high, before the row strobe falls.
- R5: After the row strobe falls, the column strobe stays low for exactly CHR cycles (the row-fall cycle included) and then returns high while the row strobe is still low.
- R6: The row strobe stays low for exactly RAS cycles per refresh. The write strobe is high at all times, including at every row-strobe fall.
- R7: The busy output is high from the cycle after a grant is taken until the end of the precharge. After each row-strobe rise, both strobes stay high for exactly RP cycles while busy is high, and then busy falls.
- R8: Once ready, the block owes one refresh every REFI = ceil(T_REFI_NS*1000/CLK_PS) cycles. The first request is seen REFI edges after ready, and with the grant held high exactly one refresh occurs per REFI cycles.
- R9: Refreshes owed but not granted build up in a backlog that is capped at MAX_BACKLOG, and further owed refreshes are dropped. On grant the backlog is served back to back, min(missed, MAX_BACKLOG) cycles in total.
- R10: The request is high only while ready, idle and the backlog is non-empty, and never while busy. A grant sampled together with the request makes the column strobe fall at the next edge. A grant with no request pending starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Bus grant from the access controller |
| ref_req | output | 1 | Refresh request towards the access controller |
| busy | output | 1 | A refresh cycle owns the strobes |
| mem_ready | output | 1 | Power-up sequence finished; normal traffic allowed |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, active low (held high) |

## Verification
A wrong phase timer shows up within one refresh cycle as a wrong count of column-lead, column-hold, row-low or precharge cycles, measured at the strobe pins. A wrong pause or init counter moves the first column-strobe fall or the ready edge away from its computed cycle. A wrong interval counter or backlog shows up within one or two intervals as a misplaced first request, or as the wrong number of row-strobe falls when missed intervals are served. The bench sweeps one through five missed intervals against a cap of three, so both the growth of the backlog and its saturation are observed at the ports.

// File: rtl/drfs_pkg.sv
package drfs_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE = 3'd0,
    ST_INIT  = 3'd1,
    ST_IDLE  = 3'd2,
    ST_CAS   = 3'd3,
    ST_HOLD  = 3'd4,
    ST_TAIL  = 3'd5,
    ST_PRE   = 3'd6
  } seq_st_e;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
  } strobe_t;

  // Round a nanosecond figure up to whole clock cycles, never below one.
  function automatic int unsigned ns_to_cyc(input int unsigned t_ns, input int unsigned clk_ps);
    int unsigned c;
    c = (t_ns * 1000 + clk_ps - 1) / clk_ps;
    if (c == 0) c = 1;
    return c;
  endfunction

  // Bits needed to hold the value n.
  function automatic int unsigned width_for(input int unsigned n);
    int unsigned w;
    w = $clog2(n + 1);
    if (w == 0) w = 1;
    return w;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Strobe levels driven in each sequencer state.
  function automatic strobe_t strobes_for(input seq_st_e s);
    strobe_t v;
    v = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    case (s)
      ST_CAS:  v.cas_n = 1'b0;
      ST_HOLD: begin v.ras_n = 1'b0; v.cas_n = 1'b0; end
      ST_TAIL: v.ras_n = 1'b0;
      default: ;
    endcase
    return v;
  endfunction

  function automatic logic is_busy(input seq_st_e s);
    return (s == ST_CAS) || (s == ST_HOLD) || (s == ST_TAIL) || (s == ST_PRE);
  endfunction

endpackage

// File: rtl/drfs_interval.sv
module drfs_interval
  import drfs_pkg::*;
#(
  parameter int unsigned REFI_CYC    = 3900,
  parameter int unsigned MAX_BACKLOG = 8,
  localparam int unsigned BW = width_for(MAX_BACKLOG),
  localparam int unsigned IW = width_for(REFI_CYC - 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          take,
  output logic          tick,
  output logic [BW-1:0] backlog,
  output logic          owed
);

  logic [IW-1:0] ictr;
  logic          inc;
  logic          at_cap;

  assign tick   = run && (ictr == IW'(REFI_CYC - 1));
  assign at_cap = (backlog == BW'(MAX_BACKLOG));
  // A tick at the cap still counts when a grant frees a slot the same cycle.
  assign inc    = tick && (!at_cap || take);
  assign owed   = (backlog != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ictr <= '0;
    end else if (!run || tick) begin
      ictr <= '0;
    end else begin
      ictr <= ictr + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      backlog <= '0;
    end else begin
      case ({inc, take})
        2'b10:   backlog <= backlog + BW'(1);
        2'b01:   backlog <= backlog - BW'(1);
        default: backlog <= backlog;
      endcase
    end
  end

endmodule

// File: rtl/drfs_seq.sv
module drfs_seq
  import drfs_pkg::*;
#(
  parameter int unsigned PAUSE_CYC = 50000,
  parameter int unsigned INIT_N    = 8,
  parameter int unsigned CSR_CYC   = 2,
  parameter int unsigned CHR_CYC   = 3,
  parameter int unsigned RAS_CYC   = 15,
  parameter int unsigned RP_CYC    = 10,
  localparam int unsigned TAIL_CYC = (RAS_CYC > CHR_CYC) ? (RAS_CYC - CHR_CYC) : 1,
  localparam int unsigned MAXD     = max2(max2(CSR_CYC, CHR_CYC), max2(TAIL_CYC, RP_CYC)),
  localparam int unsigned TW       = width_for(MAXD),
  localparam int unsigned PW       = width_for(PAUSE_CYC),
  localparam int unsigned NW       = width_for(INIT_N)
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  output seq_st_e state,
  output logic    ras_n,
  output logic    cas_n,
  output logic    we_n,
  output logic    ready,
  output logic    busy
);

  seq_st_e       state_d;
  logic [TW-1:0] tmr, tmr_d;
  logic [PW-1:0] pctr;
  logic [NW-1:0] init_left, left_d;
  logic          ready_d;
  logic          pause_end;
  logic          phase_done;
  strobe_t       strb_d;

  assign pause_end  = (state == ST_PAUSE) && (pctr == PW'(PAUSE_CYC - 1));
  assign phase_done = (tmr == '0);
  assign busy       = is_busy(state);
  assign strb_d     = strobes_for(state_d);

  always_comb begin
    state_d = state;
    tmr_d   = phase_done ? '0 : (tmr - TW'(1));
    left_d  = init_left;
    ready_d = ready;
    case (state)
      ST_PAUSE: if (pause_end) state_d = ST_INIT;
      ST_INIT: begin
        if (init_left != '0) begin
          state_d = ST_CAS;
          tmr_d   = TW'(CSR_CYC - 1);
          left_d  = init_left - NW'(1);
        end else begin
          state_d = ST_IDLE;
          ready_d = 1'b1;
        end
      end
      ST_IDLE: begin
        if (start) begin
          state_d = ST_CAS;
          tmr_d   = TW'(CSR_CYC - 1);
        end
      end
      ST_CAS: begin
        if (phase_done) begin
          state_d = ST_HOLD;
          tmr_d   = TW'(CHR_CYC - 1);
        end
      end
      ST_HOLD: begin
        if (phase_done) begin
          state_d = ST_TAIL;
          tmr_d   = TW'(TAIL_CYC - 1);
        end
      end
      ST_TAIL: begin
        if (phase_done) begin
          state_d = ST_PRE;
          tmr_d   = TW'(RP_CYC - 1);
        end
      end
      ST_PRE: begin
        if (phase_done) state_d = ready ? ST_IDLE : ST_INIT;
      end
      default: state_d = ST_PAUSE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_PAUSE;
      tmr       <= '0;
      init_left <= NW'(INIT_N);
      ready     <= 1'b0;
      ras_n     <= 1'b1;
      cas_n     <= 1'b1;
      we_n      <= 1'b1;
    end else begin
      state     <= state_d;
      tmr       <= tmr_d;
      init_left <= left_d;
      ready     <= ready_d;
      ras_n     <= strb_d.ras_n;
      cas_n     <= strb_d.cas_n;
      we_n      <= strb_d.we_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pctr <= '0;
    end else if ((state == ST_PAUSE) && !pause_end) begin
      pctr <= pctr + PW'(1);
    end
  end

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import drfs_pkg::*;
#(
  parameter int unsigned CLK_PS         = 4000,
  parameter int unsigned T_PAUSE_NS     = 200000,
  parameter int unsigned INIT_REFRESHES = 8,
  parameter int unsigned T_REFI_NS      = 15600,
  parameter int unsigned T_CSR_NS       = 5,
  parameter int unsigned T_CHR_NS       = 10,
  parameter int unsigned T_RAS_NS       = 60,
  parameter int unsigned T_RP_NS        = 40,
  parameter int unsigned MAX_BACKLOG    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_gnt,
  output logic ref_req,
  output logic busy,
  output logic mem_ready,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);

  localparam int unsigned PAUSE_CYC = ns_to_cyc(T_PAUSE_NS, CLK_PS);
  localparam int unsigned REFI_CYC  = ns_to_cyc(T_REFI_NS, CLK_PS);
  localparam int unsigned CSR_CYC   = ns_to_cyc(T_CSR_NS, CLK_PS);
  localparam int unsigned CHR_CYC   = ns_to_cyc(T_CHR_NS, CLK_PS);
  localparam int unsigned RAS_CYC   = ns_to_cyc(T_RAS_NS, CLK_PS);
  localparam int unsigned RP_CYC    = ns_to_cyc(T_RP_NS, CLK_PS);
  localparam int unsigned BW        = width_for(MAX_BACKLOG);

  seq_st_e       state;
  logic          go;
  logic          tick;
  logic          owed;
  logic [BW-1:0] backlog;

  assign ref_req = mem_ready && owed && (state == ST_IDLE);
  assign go      = ref_req && ref_gnt;

  drfs_interval #(
    .REFI_CYC   (REFI_CYC),
    .MAX_BACKLOG(MAX_BACKLOG)
  ) u_interval (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (mem_ready),
    .take   (go),
    .tick   (tick),
    .backlog(backlog),
    .owed   (owed)
  );

  drfs_seq #(
    .PAUSE_CYC(PAUSE_CYC),
    .INIT_N   (INIT_REFRESHES),
    .CSR_CYC  (CSR_CYC),
    .CHR_CYC  (CHR_CYC),
    .RAS_CYC  (RAS_CYC),
    .RP_CYC   (RP_CYC)
  ) u_seq (
    .clk  (clk),
    .rst_n(rst_n),
    .start(go),
    .state(state),
    .ras_n(ras_n),
    .cas_n(cas_n),
    .we_n (we_n),
    .ready(mem_ready),
    .busy (busy)
  );

endmodule

// File: rtl/drfs_chk.sv
module drfs_chk #(
  parameter int unsigned BW          = 4,
  parameter int unsigned MAX_BACKLOG = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ras_n,
  input logic          cas_n,
  input logic          we_n,
  input logic          busy,
  input logic          mem_ready,
  input logic          ref_req,
  input logic          ref_gnt,
  input logic          go,
  input logic          tick,
  input logic [BW-1:0] backlog
);

  // R4
  cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

  // R6
  we_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> we_n);

  // R10
  req_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> !busy);

  // R10
  grant_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_gnt) |=> (!cas_n && ras_n && busy));

  // R10
  idle_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_ready && !busy && !ref_req && ref_gnt) |=> cas_n);

  // R9
  backlog_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    backlog <= BW'(MAX_BACKLOG));

  // R9
  tick_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !go && (backlog < BW'(MAX_BACKLOG))) |=> (backlog == $past(backlog) + BW'(1)));

  // R3
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ready |=> mem_ready);

  // R7
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (ras_n && cas_n));

  // R7
  ras_rise_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> busy);

  // R2
  pause_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ready |-> !ref_req);

endmodule

bind dram_refresh_sched drfs_chk #(
  .BW         (BW),
  .MAX_BACKLOG(MAX_BACKLOG)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ras_n    (ras_n),
  .cas_n    (cas_n),
  .we_n     (we_n),
  .busy     (busy),
  .mem_ready(mem_ready),
  .ref_req  (ref_req),
  .ref_gnt  (ref_gnt),
  .go       (go),
  .tick     (tick),
  .backlog  (backlog)
);

// File: tb/sim_dram_refresh_sched.sv
`timescale 1ns/1ps
module sim_dram_refresh_sched;

  localparam int CLK_PS  = 4000;
  localparam int PAUSE   = 400;
  localparam int INITN   = 8;
  localparam int REFI    = 800;
  localparam int CSRN    = 5;
  localparam int CHRN    = 10;
  localparam int RASN    = 60;
  localparam int RPN     = 40;
  localparam int MAXB    = 3;

  // Cycle counts restated independently: whole quotient plus one if remainder.
  function automatic int cyc_of(input int ns);
    int q;
    q = (ns * 1000) / CLK_PS;
    if ((ns * 1000) % CLK_PS != 0) q = q + 1;
    if (q < 1) q = 1;
    return q;
  endfunction

  localparam int E_P    = cyc_of(PAUSE);
  localparam int E_REFI = cyc_of(REFI);
  localparam int E_CSR  = cyc_of(CSRN);
  localparam int E_CHR  = cyc_of(CHRN);
  localparam int E_RAS  = cyc_of(RASN);
  localparam int E_RP   = cyc_of(RPN);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_gnt = 1'b0;
  logic ref_req, busy, mem_ready, ras_n, cas_n, we_n;

  always #2 clk = ~clk;

  dram_refresh_sched #(
    .CLK_PS(CLK_PS), .T_PAUSE_NS(PAUSE), .INIT_REFRESHES(INITN), .T_REFI_NS(REFI),
    .T_CSR_NS(CSRN), .T_CHR_NS(CHRN), .T_RAS_NS(RASN), .T_RP_NS(RPN), .MAX_BACKLOG(MAXB)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req), .busy(busy),
    .mem_ready(mem_ready), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
  );

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Strobe monitor: measures each phase at the pins.
  logic p_ras = 1'b1, p_busy = 1'b0;
  int pre_cnt = 0, ras_lo = 0, hold_cnt = 0, rp_cnt = 0, falls = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ras_n && !cas_n) pre_cnt++;
      if (p_ras && !ras_n) begin
        check(pre_cnt == E_CSR, "R4 cas lead before ras fall", pre_cnt, E_CSR);
        check(we_n == 1'b1, "R6 we at ras fall", int'(we_n), 1);
        falls++;
        ras_lo = 1;
        hold_cnt = cas_n ? 0 : 1;
        pre_cnt = 0;
      end else if (!ras_n) begin
        ras_lo++;
        if (!cas_n) hold_cnt++;
      end
      if (!p_ras && ras_n) begin
        check(ras_lo == E_RAS, "R6 ras low width", ras_lo, E_RAS);
        check(hold_cnt == E_CHR, "R5 cas hold after ras fall", hold_cnt, E_CHR);
        rp_cnt = busy ? 1 : 0;
      end else if (ras_n && cas_n && busy) begin
        rp_cnt++;
      end
      if (p_busy && !busy) check(rp_cnt == E_RP, "R7 precharge before busy drop", rp_cnt, E_RP);
      if (ref_req && busy) check(1'b0, "R10 request while busy", 1, 0);
      if (!we_n) check(1'b0, "R6 write strobe low", 0, 1);
      p_ras = ras_n;
      p_busy = busy;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_req(input string tag);
    int n;
    n = 0;
    while (!ref_req && n < 4 * E_REFI) begin
      step();
      n++;
    end
    check(ref_req == 1'b1, tag, int'(ref_req), 1);
  endtask

  initial begin
    int t_cas, t_rdy, f0, exp_ready, n_wait;
    ref_gnt = 1'b1;
    rst_n = 1'b0;
    repeat (3) step();
    // R1 reset state
    check(ras_n == 1'b1, "R1 ras_n in reset", int'(ras_n), 1);
    check(cas_n == 1'b1, "R1 cas_n in reset", int'(cas_n), 1);
    check(we_n == 1'b1, "R1 we_n in reset", int'(we_n), 1);
    check(mem_ready == 1'b0 && busy == 1'b0 && ref_req == 1'b0, "R1 flags in reset",
          int'({mem_ready, busy, ref_req}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R2 pause with grant held high
    n_wait = 0;
    while (cas_n && n_wait < E_P + 50) begin
      if (ref_req || !ras_n) check(1'b0, "R2 activity during pause", 1, 0);
      step();
      n_wait++;
    end
    t_cas = cyc;
    check(t_cas == E_P + 1, "R2 first cas fall edge", t_cas, E_P + 1);
    // R3 init sequence
    n_wait = 0;
    while (!mem_ready && n_wait < 2000) begin
      step();
      n_wait++;
    end
    t_rdy = cyc;
    exp_ready = E_P + INITN * (1 + E_CSR + E_RAS + E_RP) + 1;
    check(t_rdy == exp_ready, "R3 ready edge", t_rdy, exp_ready);
    check(falls == INITN, "R3 init refresh count", falls, INITN);
    ref_gnt = 1'b0;
    // R8 first request
    wait_req("R8 first request");
    check(cyc - t_rdy == E_REFI, "R8 first request delay", cyc - t_rdy, E_REFI);
    // R9 sweep of missed intervals against the cap
    for (int n = 1; n <= 5; n++) begin
      repeat ((n - 1) * E_REFI + 20) step();
      check(ref_req == 1'b1, "R9 request pending with backlog", int'(ref_req), 1);
      f0 = falls;
      ref_gnt = 1'b1;
      step();
      check(!cas_n && ras_n && busy, "R10 cas fall after grant / R7 busy",
            int'({cas_n, ras_n, busy}), 3'b011);
      repeat (99) step();
      check(falls - f0 == ((n < MAXB) ? n : MAXB), "R9 served backlog",
            falls - f0, (n < MAXB) ? n : MAXB);
      f0 = falls;
      repeat (50) step();
      check(falls == f0 && ras_n && cas_n && !ref_req, "R10 grant without request",
            falls - f0, 0);
      ref_gnt = 1'b0;
      wait_req("R8 next interval request");
    end
    // R8 steady state: one refresh per interval with grant held
    ref_gnt = 1'b1;
    f0 = falls;
    repeat (2 * E_REFI) step();
    check(falls - f0 == 2, "R8 refreshes over two intervals", falls - f0, 2);
    check(mem_ready == 1'b1, "R3 ready stays high", int'(mem_ready), 1);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule